// File: doc/BRIEF.md
# Upset-Tolerant Single-Slope Monitor Converter Controller

This block is the digital core of a slow monitoring converter. It sits behind a serial-bus slave that turns host transactions into simple byte-wide register reads and writes. Through those registers the host picks one of eight analog inputs, starts a conversion and reads back a 12-bit result. Input 0 is the on-chip temperature sensor. Inputs 1 to 7 are external voltages.

A conversion first pulses the ramp discharge line for one cycle and then lets the ramp rise while a counter advances once per clock. The first clock on which the external comparator reports a trip freezes the count as the result. If the comparator never trips, the result stops at full scale and an overflow flag is raised. All held state is kept in three copies. A bitwise majority vote resolves the state on every clock, and the voted value is written back to all copies, so a single upset is removed on the next clock. An injection port lets the bench corrupt one bit of one copy.

Register map, with the 2-bit address: 0 is control (write bits 2:0 = channel, bit 7 = start; reads back the channel, with bit 7 always 0). 1 is status (bit 0 busy, bit 1 done, bit 2 overflow). 2 holds the result bits 11:8 in its bits 3:0. 3 holds the result bits 7:0. The register port has no back-pressure: reads return data in the same cycle and writes take effect at the next clock edge.

Top module: `envmon_conv_ctrl`

## Requirements
- R1: After reset, status reads 0, the result reads 0, `mux_sel` is 0, and both `ramp_clr` and `ramp_go` are low.
- R2: A write to address 0 with bit 7 set while idle copies bits 2:0 to `mux_sel` and sets busy. `ramp_clr` is high for exactly the next cycle, and then `ramp_go` rises.
- R3: The result equals the number of clocks `ramp_go` was high before the clock on which `cmp_trip` is first sampled high. The count starts at 0. At that clock done is set, busy clears and `ramp_go` falls. The result reads back as address 2 bits 3:0 = result 11:8 and address 3 = result 7:0.
- R4: If the count reaches 4095 and the comparator has not tripped, the result saturates at 4095, overflow (status bit 2) is set and the conversion ends. A trip sampled at count 4095 gives 4095 with no overflow.
- R5: A start written while busy is ignored and `mux_sel` does not change. The written channel is stored for readback at address 0, and it reaches `mux_sel` at the next accepted start.
- R6: The start bit clears itself: address 0 bit 7 always reads 0.
- R7: Reading address 3 clears done. Reading address 2 does not. A new start clears done and overflow.
- R8: `sensor_en` is high exactly when `mux_sel` is 0, the temperature-sensor channel.
- R9: A pulse on `flip_en` inverts bit `flip_idx` of copy `flip_copy` (copy 0 to 2; 3 = none). The result occupies flattened state bits 11:0. A single corrupted copy changes no output.
- R10: After an upset, all three copies hold the voted value again one clock later. A second upset of the same bit in a different copy therefore still changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock, about 4 MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (has a side effect on address 3) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from the address |
| cmp_trip | input | 1 | Comparator output, high once the ramp exceeds the input |
| mux_sel | output | 3 | Analog multiplexer select |
| sensor_en | output | 1 | Temperature-sensor bias enable |
| ramp_clr | output | 1 | Ramp discharge pulse |
| ramp_go | output | 1 | Ramp run enable |
| flip_en | input | 1 | Upset injection strobe |
| flip_copy | input | 2 | Copy to corrupt (3 = none) |
| flip_idx | input | 6 | Bit of the flattened state to corrupt |

## Verification
The hardest case to reach from the ports is a hidden disagreement between the three copies. The voted outputs mask it by design, so one upset shows nothing at the pins. The bench flips a result bit in one copy and confirms the readback is unchanged. It then flips the same bit in a second copy. If the first error had not been scrubbed, two copies would now outvote the third and the readback would change. The comparator is modelled as a counter of `ramp_go` cycles against a per-vector threshold. One threshold lies above full scale, which drives the saturation path.

// File: rtl/envmon_pkg.sv
package envmon_pkg;
  localparam int RES_W = 12;
  localparam int CH_W  = 3;
  localparam logic [RES_W-1:0] FULL_SCALE = {RES_W{1'b1}};

  typedef enum logic [1:0] {SQ_IDLE, SQ_PRIME, SQ_COUNT} seq_e;

  // result sits in the low bits of the flattened vector
  typedef struct packed {
    logic [CH_W-1:0]  ch_sel;
    logic [CH_W-1:0]  run_ch;
    logic             busy;
    logic             done;
    logic             ovf;
    seq_e             sq;
    logic [RES_W-1:0] cnt;
    logic [RES_W-1:0] res;
  } st_t;

  localparam int ST_W  = $bits(st_t);
  localparam int IDX_W = $clog2(ST_W);
endpackage

// File: rtl/envmon_tmr_reg.sv
module envmon_tmr_reg #(
  parameter int W = 8,
  parameter int IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  d,
  output logic [W-1:0]  q,
  input  logic          flip_en,
  input  logic [1:0]    flip_copy,
  input  logic [IW-1:0] flip_idx
);
  logic [W-1:0] cp [3];
  logic [W-1:0] hit;

  assign hit = W'(1) << flip_idx;

  for (genvar c = 0; c < 3; c++) begin : g_copy
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cp[c] <= '0;
      else if (flip_en && flip_copy == 2'(c)) cp[c] <= d ^ hit;
      else cp[c] <= d;
    end
  end

  assign q = (cp[0] & cp[1]) | (cp[0] & cp[2]) | (cp[1] & cp[2]);

  // R10
  scrub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(flip_en) |-> (cp[0] == cp[1] && cp[1] == cp[2]));
  // R9
  single_upset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones((cp[0] ^ q) | (cp[1] ^ q) | (cp[2] ^ q)) <= 1);
endmodule

// File: rtl/envmon_seq_next.sv
module envmon_seq_next
  import envmon_pkg::*;
(
  input  st_t        cur,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  input  logic       cmp_trip,
  output st_t        nxt
);
  always_comb begin
    nxt = cur;
    if (reg_rd && reg_addr == 2'd3) nxt.done = 1'b0;
    unique case (cur.sq)
      SQ_PRIME: begin
        nxt.sq  = SQ_COUNT;
        nxt.cnt = '0;
      end
      SQ_COUNT: begin
        if (cmp_trip) begin
          nxt.res  = cur.cnt;
          nxt.done = 1'b1;
          nxt.busy = 1'b0;
          nxt.sq   = SQ_IDLE;
        end else if (cur.cnt == FULL_SCALE) begin
          nxt.res  = FULL_SCALE;
          nxt.ovf  = 1'b1;
          nxt.done = 1'b1;
          nxt.busy = 1'b0;
          nxt.sq   = SQ_IDLE;
        end else begin
          nxt.cnt = cur.cnt + 1'b1;
        end
      end
      default: ;
    endcase
    if (reg_wr && reg_addr == 2'd0) begin
      nxt.ch_sel = reg_wdata[CH_W-1:0];
      if (reg_wdata[7] && !cur.busy) begin
        nxt.run_ch = reg_wdata[CH_W-1:0];
        nxt.busy   = 1'b1;
        nxt.done   = 1'b0;
        nxt.ovf    = 1'b0;
        nxt.sq     = SQ_PRIME;
        nxt.cnt    = '0;
      end
    end
  end
endmodule

// File: rtl/envmon_conv_ctrl.sv
module envmon_conv_ctrl
  import envmon_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [1:0]       reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             cmp_trip,
  output logic [CH_W-1:0]  mux_sel,
  output logic             sensor_en,
  output logic             ramp_clr,
  output logic             ramp_go,
  input  logic             flip_en,
  input  logic [1:0]       flip_copy,
  input  logic [IDX_W-1:0] flip_idx
);
  st_t cur, nxt;
  logic [ST_W-1:0] q_flat;

  envmon_seq_next u_next (
    .cur(cur), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .cmp_trip(cmp_trip), .nxt(nxt)
  );

  envmon_tmr_reg #(.W(ST_W), .IW(IDX_W)) u_state (
    .clk(clk), .rst_n(rst_n), .d(nxt), .q(q_flat),
    .flip_en(flip_en), .flip_copy(flip_copy), .flip_idx(flip_idx)
  );
  assign cur = st_t'(q_flat);

  assign mux_sel   = cur.run_ch;
  assign sensor_en = (cur.run_ch == '0);
  assign ramp_clr  = (cur.sq == SQ_PRIME);
  assign ramp_go   = (cur.sq == SQ_COUNT);

  always_comb begin
    unique case (reg_addr)
      2'd0: reg_rdata = 8'(cur.ch_sel);
      2'd1: reg_rdata = {5'b0, cur.ovf, cur.done, cur.busy};
      2'd2: reg_rdata = 8'(cur.res[RES_W-1:8]);
      default: reg_rdata = cur.res[7:0];
    endcase
  end

  // R2
  ramp_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_clr |=> ramp_go);
  // R2
  ramp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ramp_clr && ramp_go));
  // R5
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur.busy && reg_wr && reg_addr == 2'd0) |=> $stable(mux_sel));
  // R4
  sat_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur.ovf |-> (cur.res == FULL_SCALE));
  // R7
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cur.busy && reg_rd && reg_addr == 2'd3) |=> !cur.done);
endmodule

// File: tb/envmon_conv_ctrl_tb.sv
module envmon_conv_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 150000;

  typedef struct packed {
    logic [7:0]  ch;
    logic [15:0] thr;
    logic [15:0] exp_res;
    logic        exp_ovf;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{8'd3, 16'd0,    16'd0,    1'b0},
    '{8'd0, 16'd1,    16'd1,    1'b0},
    '{8'd5, 16'd37,   16'd37,   1'b0},
    '{8'd7, 16'd300,  16'd300,  1'b0},
    '{8'd2, 16'd4095, 16'd4095, 1'b0},
    '{8'd1, 16'd5000, 16'd4095, 1'b1}
  };

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic cmp_trip;
  logic [2:0] mux_sel;
  logic sensor_en, ramp_clr, ramp_go;
  logic flip_en = 0;
  logic [1:0] flip_copy = 2'd3;
  logic [5:0] flip_idx = 0;

  int checks = 0, errors = 0, cycles = 0;
  int thr = 0;
  int ramp_cnt = 0;
  logic [7:0] rd_val;

  always #(CLK_PERIOD/2) clk = ~clk;

  // comparator model: trips once ramp has been running thr cycles
  always_ff @(posedge clk) ramp_cnt <= ramp_go ? ramp_cnt + 1 : 0;
  assign cmp_trip = ramp_go && (ramp_cnt >= thr);

  envmon_conv_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cmp_trip(cmp_trip), .mux_sel(mux_sel), .sensor_en(sensor_en),
    .ramp_clr(ramp_clr), .ramp_go(ramp_go), .flip_en(flip_en),
    .flip_copy(flip_copy), .flip_idx(flip_idx)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      peek(2'd1, s);
      if (!s[0]) break;
    end
  endtask

  task automatic flip(input logic [1:0] c, input logic [5:0] b);
    @(negedge clk);
    flip_en = 1; flip_copy = c; flip_idx = b;
    @(negedge clk);
    flip_en = 0; flip_copy = 2'd3;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == WATCHDOG) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, v2;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    peek(2'd1, v); check("R1 status", v, 0);
    peek(2'd2, v); check("R1 result hi", v, 0);
    peek(2'd3, v); check("R1 result lo", v, 0);
    check("R1 mux_sel", mux_sel, 0);
    check("R1 ramps", {ramp_clr, ramp_go}, 0);

    foreach (VEC[i]) begin
      thr = VEC[i].thr;
      wr(2'd0, 8'h80 | VEC[i].ch);
      // one edge after the write: prime cycle
      check("R2 ramp_clr", ramp_clr, 1);
      check("R2 mux_sel", mux_sel, VEC[i].ch);
      peek(2'd1, v); check("R2 busy", v[0], 1);
      peek(2'd0, v); check("R6 start self-clear", v[7], 0);
      @(negedge clk);
      check("R2 ramp_go", {ramp_clr, ramp_go}, 1);
      check("R8 sensor_en", sensor_en, VEC[i].ch == 0);
      wait_idle();
      check("R3 ramp_go low", ramp_go, 0);
      peek(2'd1, v);
      check("R3 done", v[1], 1);
      check("R4 overflow", v[2], VEC[i].exp_ovf);
      rd(2'd2, v);
      check("R3 result hi", v, VEC[i].exp_res[11:8]);
      peek(2'd1, v2); check("R7 done kept after hi read", v2[1], 1);
      rd(2'd3, v2);
      check("R3 result lo", v2, VEC[i].exp_res[7:0]);
      peek(2'd1, v); check("R7 done cleared", v[1], 0);
    end

    // R5 start while busy ignored, channel takes effect at next start
    thr = 120;
    wr(2'd0, 8'h82);
    repeat (10) @(negedge clk);
    wr(2'd0, 8'h86);
    check("R5 mux_sel held", mux_sel, 2);
    peek(2'd0, v); check("R5 channel readback", v, 6);
    wait_idle();
    rd(2'd3, v); check("R5 result unaffected", v, 120);
    thr = 4;
    wr(2'd0, 8'h80 | 8'h06);
    check("R5 new channel on start", mux_sel, 6);
    check("R8 sensor off", sensor_en, 0);
    wait_idle();
    peek(2'd3, v); check("R5 second result", v, 4);

    // R7 new start clears done and overflow
    thr = 5000;
    wr(2'd0, 8'h81);
    wait_idle();
    peek(2'd1, v); check("R4 overflow set", v[2], 1);
    thr = 9;
    wr(2'd0, 8'h81);
    peek(2'd1, v); check("R7 start clears flags", v[2:1], 0);
    wait_idle();
    peek(2'd3, v); check("R3 after overflow", v, 9);

    // R9 / R10 upset injection on result bit 0 (result = 9)
    flip(2'd0, 6'd0);
    peek(2'd3, v); check("R9 single upset masked", v, 9);
    flip(2'd1, 6'd0);
    peek(2'd3, v); check("R10 scrubbed before second upset", v, 9);
    flip(2'd2, 6'd3);
    peek(2'd3, v); check("R9 copy2 upset masked", v, 9);
    peek(2'd1, v); check("R9 status unchanged", v, 2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule